// File: doc/BRIEF.md
# Interrupt Source Table Controller

This block holds the routing state for a fixed set of interrupt sources. Each source keeps a destination server number and an 8-bit priority. Each source is also built as either a level-sensitive input or an edge-triggered message input. A priority of all ones masks the source. When a source needs service, the block issues a delivery request on a single output channel. The request carries the server, the global source number and the priority. Global numbers are the local index plus a fixed base of 16.

A downstream presentation stage may bounce a request back with a reject notice. It also returns end-of-interrupt notices, and it may ask for a resend. A resend walks the whole table, one source per clock. During the walk, level sources that are still asserted and unmasked are presented again. Message sources that were bounced are also replayed. A message that arrives while its source is masked is remembered, and it is issued when a configuration write unmasks the source. Configuration writes and reads address sources by global number. An address outside the table raises an error flag instead of taking effect.

Top module: `ics_source_ctrl`

## Requirements
- R1: A global number is accepted only when 16 <= number < 16 + NUM_SRC. A configuration write or read to any other number raises `err_o` in the following cycle. Such a write changes no source, and such a read does not raise `rd_valid_o`.
- R2: After reset, every source has priority 8'hFF and server 0. No delivery is pending, and `busy_o` is low.
- R3: Bit i of parameter LEVEL_MAP selects the kind of source i (1 = level, 0 = message); the default makes sources 0..3 level and 4..7 message. When a message source's line rises while its priority is not 8'hFF, one delivery is issued. If the priority is 8'hFF, the event is stored as masked-pending instead.
- R4: A configuration write that gives a masked-pending message source a priority other than 8'hFF clears the flag and issues one delivery. Later writes do not repeat that delivery.
- R5: A level source issues a delivery and marks itself sent only when three conditions hold: it is asserted, its priority is not 8'hFF, and it is not already sent. This check runs on a change of its line, on a configuration write to it, and when the resend walk visits it.
- R6: A reject notice for a valid number marks that source rejected and clears its sent mark, for both kinds of source.
- R7: An end-of-interrupt notice clears the sent mark of a level source. It has no effect on a message source.
- R8: During a resend walk, a rejected message source has its rejected mark cleared. It is delivered again only if its priority is not 8'hFF.
- R9: A configuration read of a valid number returns that source's stored server and priority, with `rd_valid_o` high, one cycle after the request.
- R10: A resend request starts a walk that keeps `busy_o` high for NUM_SRC cycles. A request that arrives during a walk starts one more full walk right after the current one ends.
- R11: At most one delivery is issued per clock. Sources waiting at the same time are served in ascending index order.
- R12: No delivery carries priority 8'hFF. A queued delivery whose source becomes masked waits until the source is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_line_i | input | NUM_SRC | Per-source interrupt lines |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_rd_i | input | 1 | Configuration read strobe |
| cfg_num_i | input | NUM_W | Global source number for write/read |
| cfg_srv_i | input | SRV_W | Server to store |
| cfg_prio_i | input | 8 | Priority to store (8'hFF masks) |
| rd_valid_o | output | 1 | Read data valid |
| rd_srv_o | output | SRV_W | Read server |
| rd_prio_o | output | 8 | Read priority |
| err_o | output | 1 | Previous write/read addressed an invalid number |
| rej_i | input | 1 | Reject notice strobe |
| rej_num_i | input | NUM_W | Global number of rejected source |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | NUM_W | Global number of finished source |
| resend_i | input | 1 | Resend request |
| busy_o | output | 1 | Resend walk in progress |
| dlv_valid_o | output | 1 | Delivery request valid |
| dlv_srv_o | output | SRV_W | Delivery target server |
| dlv_num_o | output | NUM_W | Delivery global source number |
| dlv_prio_o | output | 8 | Delivery priority |

## Verification
Some properties are checked by assertions in every cycle:
- a delivery never carries the mask priority and always names an in-range global number;
- only one source is granted per clock, and only if it has something queued;
- a level source's queued request always comes with its sent mark;
- masked-pending is only ever recorded while the source is masked;
- the walk index stays in range and steps by one.

The bench scenarios show the behaviour that depends on event history. This covers replay after reject and after end-of-interrupt. It covers the difference between message and level sources, the single release of a masked-pending event, and the ascending service order. It also covers the length of a walk, and the walk that is restarted when a resend arrives during a scan.

// File: rtl/ics_pkg.sv
// Package: shared constants for the interrupt source table controller.
// Assumes priorities are 8 bits wide and that all ones means masked.
package ics_pkg;
    localparam int unsigned PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;

    typedef enum logic {
        KIND_MSG = 1'b0,
        KIND_LVL = 1'b1
    } src_kind_e;
endpackage

// File: rtl/ics_num_decode.sv
// Module: ics_num_decode
// Turns a global source number into a local table index and a valid flag.
// Assumes OFFSET + NUM_SRC fits in NUM_W bits. Purely combinational.
module ics_num_decode #(
    parameter int unsigned NUM_W   = 12,
    parameter int unsigned OFFSET  = 16,
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [NUM_W-1:0] num_i,
    output logic             ok_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [NUM_W-1:0] LO = NUM_W'(OFFSET);
    localparam logic [NUM_W-1:0] HI = NUM_W'(OFFSET + NUM_SRC);

    // Range test and base removal.
    always_comb begin
        ok_o  = (num_i >= LO) && (num_i < HI);
        idx_o = IDX_W'(num_i - LO);
    end
endmodule

// File: rtl/ics_src_slot.sv
// Module: ics_src_slot
// State of one interrupt source: routing fields, line history and the
// sent / rejected / masked-pending / queued marks. IS_LEVEL picks the kind.
// Events arriving in one cycle are applied in this order: grant, configuration,
// line event, reject, end-of-interrupt, walk visit, level check.
// Assumes the hit strobes are already qualified by a valid number.
module ics_src_slot
    import ics_pkg::*;
#(
    parameter int unsigned SRV_W    = 4,
    parameter bit          IS_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic              cfg_hit_i,
    input  logic [SRV_W-1:0]  cfg_srv_i,
    input  logic [PRIO_W-1:0] cfg_prio_i,
    input  logic              rej_hit_i,
    input  logic              eoi_hit_i,
    input  logic              scan_hit_i,
    input  logic              grant_i,
    output logic [SRV_W-1:0]  srv_o,
    output logic [PRIO_W-1:0] prio_o,
    output logic              elig_o
);
    localparam src_kind_e KIND = IS_LEVEL ? KIND_LVL : KIND_MSG;

    logic [SRV_W-1:0]  srv_q,  srv_n;
    logic [PRIO_W-1:0] prio_q, prio_n;
    logic              line_q;
    logic              sent_q, sent_n;
    logic              rej_q,  rej_n;
    logic              mpend_q, mpend_n;
    logic              dq_q,   dq_n;

    // Next-state evaluation of all per-source marks.
    always_comb begin
        srv_n   = srv_q;
        prio_n  = prio_q;
        sent_n  = sent_q;
        rej_n   = rej_q;
        mpend_n = mpend_q;
        dq_n    = dq_q;
        if (grant_i) begin
            dq_n = 1'b0;
        end
        if (cfg_hit_i) begin
            srv_n  = cfg_srv_i;
            prio_n = cfg_prio_i;
            if (KIND == KIND_MSG && mpend_q && cfg_prio_i != PRIO_MASKED) begin
                mpend_n = 1'b0;
                dq_n    = 1'b1;
            end
        end
        if (KIND == KIND_MSG && line_i && !line_q) begin
            if (prio_n == PRIO_MASKED) begin
                mpend_n = 1'b1;
            end else begin
                dq_n = 1'b1;
            end
        end
        if (rej_hit_i) begin
            rej_n  = 1'b1;
            sent_n = 1'b0;
        end
        if (eoi_hit_i && KIND == KIND_LVL) begin
            sent_n = 1'b0;
        end
        if (scan_hit_i && KIND == KIND_MSG && rej_n) begin
            rej_n = 1'b0;
            if (prio_n != PRIO_MASKED) begin
                dq_n = 1'b1;
            end
        end
        if (KIND == KIND_LVL && (cfg_hit_i || (line_i != line_q) || scan_hit_i)
            && prio_n != PRIO_MASKED && line_i && !sent_n) begin
            sent_n = 1'b1;
            dq_n   = 1'b1;
        end
    end

    // Register update with synchronous reset to masked, idle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srv_q   <= '0;
            prio_q  <= PRIO_MASKED;
            line_q  <= 1'b0;
            sent_q  <= 1'b0;
            rej_q   <= 1'b0;
            mpend_q <= 1'b0;
            dq_q    <= 1'b0;
        end else begin
            srv_q   <= srv_n;
            prio_q  <= prio_n;
            line_q  <= line_i;
            sent_q  <= sent_n;
            rej_q   <= rej_n;
            mpend_q <= mpend_n;
            dq_q    <= dq_n;
        end
    end

    // Outputs: a queued request is offered only while unmasked.
    always_comb begin
        srv_o  = srv_q;
        prio_o = prio_q;
        elig_o = dq_q && (prio_q != PRIO_MASKED);
    end

    AST_LVL_QUEUE_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (KIND == KIND_LVL && $rose(dq_q)) |-> sent_q)
        else $error("level source queued without sent mark"); // R5
    AST_MPEND_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mpend_q) |-> (prio_q == PRIO_MASKED))
        else $error("masked-pending set while unmasked"); // R3
endmodule

// File: rtl/ics_pick_lowest.sv
// Module: ics_pick_lowest
// Fixed-priority picker: grants the lowest-index requester.
// Combinational; assumes N >= 1.
module ics_pick_lowest #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     grant_o
);
    // Scan downward so the lowest set index is the one kept.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // One-hot grant built from the chosen index.
    for (genvar g = 0; g < N; g++) begin : g_grant
        assign grant_o[g] = any_o && (idx_o == IDX_W'(g));
    end
endmodule

// File: rtl/ics_rescan.sv
// Module: ics_rescan
// Resend walk sequencer: visits indices 0..N-1, one per clock.
// A request seen during a walk is remembered and triggers one further walk.
module ics_rescan #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic again_q;

    // Walk counter, busy flag and pending-restart flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            idx_o   <= '0;
            again_q <= 1'b0;
        end else if (!busy_o) begin
            again_q <= 1'b0;
            if (start_i) begin
                busy_o <= 1'b1;
                idx_o  <= '0;
            end
        end else begin
            if (start_i) begin
                again_q <= 1'b1;
            end
            if (idx_o == LAST) begin
                if (again_q || start_i) begin
                    idx_o   <= '0;
                    again_q <= 1'b0;
                end else begin
                    busy_o <= 1'b0;
                end
            end else begin
                idx_o <= idx_o + 1'b1;
            end
        end
    end

    AST_SCAN_IDX_OK: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (idx_o <= LAST))
        else $error("walk index out of range"); // R10
    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && idx_o != '0) |-> (idx_o == $past(idx_o) + 1'b1))
        else $error("walk index skipped"); // R10
endmodule

// File: rtl/ics_source_ctrl.sv
// Module: ics_source_ctrl (top)
// Interrupt source table: NUM_SRC slots, number decoders for the config,
// reject and end-of-interrupt ports, a resend walk and a lowest-index picker
// that drives one registered delivery per clock.
// Assumes NUM_SRC <= 32 (LEVEL_MAP is a 32-bit mask) and NUM_SRC >= 2.
module ics_source_ctrl
    import ics_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 8,
    parameter int unsigned OFFSET    = 16,
    parameter int unsigned NUM_W     = 12,
    parameter int unsigned SRV_W     = 4,
    parameter int unsigned LEVEL_MAP = 32'h0000_000F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_line_i,
    input  logic               cfg_wr_i,
    input  logic               cfg_rd_i,
    input  logic [NUM_W-1:0]   cfg_num_i,
    input  logic [SRV_W-1:0]   cfg_srv_i,
    input  logic [7:0]         cfg_prio_i,
    output logic               rd_valid_o,
    output logic [SRV_W-1:0]   rd_srv_o,
    output logic [7:0]         rd_prio_o,
    output logic               err_o,
    input  logic               rej_i,
    input  logic [NUM_W-1:0]   rej_num_i,
    input  logic               eoi_i,
    input  logic [NUM_W-1:0]   eoi_num_i,
    input  logic               resend_i,
    output logic               busy_o,
    output logic               dlv_valid_o,
    output logic [SRV_W-1:0]   dlv_srv_o,
    output logic [NUM_W-1:0]   dlv_num_o,
    output logic [7:0]         dlv_prio_o
);
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [NUM_W-1:0] BASE = NUM_W'(OFFSET);
    localparam logic [NUM_W-1:0] TOP  = NUM_W'(OFFSET + NUM_SRC);

    logic             cfg_ok, rej_ok, eoi_ok;
    logic [IDX_W-1:0] cfg_idx, rej_idx, eoi_idx;
    logic             scan_busy;
    logic [IDX_W-1:0] scan_idx;
    logic [NUM_SRC-1:0] elig, grant;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic [SRV_W-1:0]  srv_a  [NUM_SRC];
    logic [PRIO_W-1:0] prio_a [NUM_SRC];

    ics_num_decode #(.NUM_W(NUM_W), .OFFSET(OFFSET), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W))
        u_dec_cfg (.num_i(cfg_num_i), .ok_o(cfg_ok), .idx_o(cfg_idx));
    ics_num_decode #(.NUM_W(NUM_W), .OFFSET(OFFSET), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W))
        u_dec_rej (.num_i(rej_num_i), .ok_o(rej_ok), .idx_o(rej_idx));
    ics_num_decode #(.NUM_W(NUM_W), .OFFSET(OFFSET), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W))
        u_dec_eoi (.num_i(eoi_num_i), .ok_o(eoi_ok), .idx_o(eoi_idx));

    ics_rescan #(.N(NUM_SRC), .IDX_W(IDX_W)) u_rescan (
        .clk(clk), .rst_n(rst_n), .start_i(resend_i),
        .busy_o(scan_busy), .idx_o(scan_idx)
    );

    // One slot per source; the kind comes from LEVEL_MAP.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
        localparam bit LVL = ((LEVEL_MAP >> s) & 1) != 0;
        logic cfg_hit, rej_hit, eoi_hit, scan_hit;
        assign cfg_hit  = cfg_wr_i && cfg_ok && (cfg_idx == IDX_W'(s));
        assign rej_hit  = rej_i && rej_ok && (rej_idx == IDX_W'(s));
        assign eoi_hit  = eoi_i && eoi_ok && (eoi_idx == IDX_W'(s));
        assign scan_hit = scan_busy && (scan_idx == IDX_W'(s));
        ics_src_slot #(.SRV_W(SRV_W), .IS_LEVEL(LVL)) u_slot (
            .clk(clk), .rst_n(rst_n), .line_i(src_line_i[s]),
            .cfg_hit_i(cfg_hit), .cfg_srv_i(cfg_srv_i), .cfg_prio_i(cfg_prio_i),
            .rej_hit_i(rej_hit), .eoi_hit_i(eoi_hit), .scan_hit_i(scan_hit),
            .grant_i(grant[s]),
            .srv_o(srv_a[s]), .prio_o(prio_a[s]), .elig_o(elig[s])
        );
    end

    ics_pick_lowest #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req_i(elig), .any_o(pick_any), .idx_o(pick_idx), .grant_o(grant)
    );

    assign busy_o = scan_busy;

    // Registered delivery channel fed by the picker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid_o <= 1'b0;
            dlv_srv_o   <= '0;
            dlv_num_o   <= '0;
            dlv_prio_o  <= '0;
        end else begin
            dlv_valid_o <= pick_any;
            if (pick_any) begin
                dlv_srv_o  <= srv_a[pick_idx];
                dlv_num_o  <= BASE + NUM_W'(pick_idx);
                dlv_prio_o <= prio_a[pick_idx];
            end
        end
    end

    // Registered configuration read response and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_srv_o   <= '0;
            rd_prio_o  <= '0;
            err_o      <= 1'b0;
        end else begin
            rd_valid_o <= cfg_rd_i && cfg_ok;
            err_o      <= (cfg_wr_i || cfg_rd_i) && !cfg_ok;
            if (cfg_rd_i && cfg_ok) begin
                rd_srv_o  <= srv_a[cfg_idx];
                rd_prio_o <= prio_a[cfg_idx];
            end
        end
    end

    AST_DLV_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid_o |-> (dlv_prio_o != PRIO_MASKED))
        else $error("masked priority delivered"); // R12
    AST_DLV_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid_o |-> (dlv_num_o >= BASE && dlv_num_o < TOP))
        else $error("delivery number out of range"); // R1
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~elig) == '0))
        else $error("grant not single or not requested"); // R11
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(cfg_wr_i || cfg_rd_i))
        else $error("error flag without access"); // R1
    AST_RD_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid_o && err_o))
        else $error("read valid together with error"); // R9
endmodule

// File: tb/ics_source_ctrl_tb.sv
// Scoreboard bench: stimulus tasks push expected deliveries into a queue and
// a negedge monitor pops and compares each delivery the design produces.
module ics_source_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int NW = 12;
    localparam int SW = 4;
    localparam int ITEM_W = SW + NW + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_line = '0;
    logic cfg_wr = 0, cfg_rd = 0;
    logic [NW-1:0] cfg_num = '0;
    logic [SW-1:0] cfg_srv = '0;
    logic [7:0] cfg_prio = '0;
    logic rd_valid, err;
    logic [SW-1:0] rd_srv;
    logic [7:0] rd_prio;
    logic rej = 0, eoi = 0, resend = 0;
    logic [NW-1:0] rej_num = '0, eoi_num = '0;
    logic busy, dlv_valid;
    logic [SW-1:0] dlv_srv;
    logic [NW-1:0] dlv_num;
    logic [7:0] dlv_prio;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R2";
    logic [ITEM_W-1:0] sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ics_source_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_line_i(src_line),
        .cfg_wr_i(cfg_wr), .cfg_rd_i(cfg_rd), .cfg_num_i(cfg_num),
        .cfg_srv_i(cfg_srv), .cfg_prio_i(cfg_prio),
        .rd_valid_o(rd_valid), .rd_srv_o(rd_srv), .rd_prio_o(rd_prio), .err_o(err),
        .rej_i(rej), .rej_num_i(rej_num), .eoi_i(eoi), .eoi_num_i(eoi_num),
        .resend_i(resend), .busy_o(busy),
        .dlv_valid_o(dlv_valid), .dlv_srv_o(dlv_srv), .dlv_num_o(dlv_num),
        .dlv_prio_o(dlv_prio)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every delivery must match the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n && dlv_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, {cur_req, " unexpected delivery"}, {8'h0, dlv_srv, dlv_num, dlv_prio}, 32'h0);
            end else begin
                logic [ITEM_W-1:0] e;
                e = sb_q.pop_front();
                chk({dlv_srv, dlv_num, dlv_prio} == e, {cur_req, " delivery"},
                    32'({dlv_srv, dlv_num, dlv_prio}), 32'(e));
            end
        end
    end

    task automatic expect_dlv(input int srv, input int num, input int prio);
        sb_q.push_back({SW'(srv), NW'(num), 8'(prio)});
    endtask

    // Wait until expectations are drained and no walk runs, then confirm.
    task automatic settle();
        int t = 0;
        while ((sb_q.size() != 0 || busy) && t < 80) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        chk(sb_q.size() == 0, {cur_req, " pending expectations"}, 32'(sb_q.size()), 32'h0);
    endtask

    task automatic cfg_write(input int num, input int srv, input int prio, output bit e);
        @(negedge clk);
        cfg_wr = 1; cfg_num = NW'(num); cfg_srv = SW'(srv); cfg_prio = 8'(prio);
        @(negedge clk);
        cfg_wr = 0;
        e = err;
    endtask

    task automatic cfg_read(input int num, output logic [SW-1:0] s, output logic [7:0] p,
                            output bit v, output bit e);
        @(negedge clk);
        cfg_rd = 1; cfg_num = NW'(num);
        @(negedge clk);
        cfg_rd = 0;
        s = rd_srv; p = rd_prio; v = rd_valid; e = err;
    endtask

    task automatic pulse_rej(input int num);
        @(negedge clk); rej = 1; rej_num = NW'(num);
        @(negedge clk); rej = 0;
    endtask

    task automatic pulse_eoi(input int num);
        @(negedge clk); eoi = 1; eoi_num = NW'(num);
        @(negedge clk); eoi = 0;
    endtask

    task automatic pulse_resend();
        @(negedge clk); resend = 1;
        @(negedge clk); resend = 0;
    endtask

    task automatic set_line(input int idx, input bit v);
        @(negedge clk); src_line[idx] = v;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [SW-1:0] s;
        logic [7:0] p;
        bit v, e;
        int cnt;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2: reset state
        cur_req = "R2";
        chk(dlv_valid == 0, "R2 no delivery", 32'(dlv_valid), 0);
        chk(busy == 0, "R2 busy low", 32'(busy), 0);
        cfg_read(23, s, p, v, e);
        chk(p == 8'hFF, "R2 reset priority", 32'(p), 32'hFF);
        chk(s == 0, "R2 reset server", 32'(s), 0);

        // R9: write then read back
        cur_req = "R9";
        cfg_write(20, 3, 5, e);
        cfg_read(20, s, p, v, e);
        chk(v == 1, "R9 read valid", 32'(v), 1);
        chk(s == 3 && p == 5, "R9 read data", {24'h0, s, 4'h0} | 32'(p), 32'h35);

        // R3: message edge while unmasked
        cur_req = "R3";
        expect_dlv(3, 20, 5);
        set_line(4, 1); set_line(4, 0);
        settle();

        // R3/R4: masked message is held, then released once by unmask
        cur_req = "R3";
        set_line(5, 1); set_line(5, 0);
        settle();
        cur_req = "R4";
        expect_dlv(2, 21, 7);
        cfg_write(21, 2, 7, e);
        settle();
        cfg_write(21, 2, 6, e);
        settle();

        // R5: level source delivered once while held
        cur_req = "R5";
        cfg_write(16, 1, 3, e);
        expect_dlv(1, 16, 3);
        set_line(0, 1);
        settle();
        pulse_resend();
        settle();

        // R7: end-of-interrupt clears sent, resend replays
        cur_req = "R7";
        pulse_eoi(16);
        settle();
        expect_dlv(1, 16, 3);
        pulse_resend();
        settle();

        // R6: reject clears sent of a level source
        cur_req = "R6";
        pulse_rej(16);
        expect_dlv(1, 16, 3);
        pulse_resend();
        settle();
        cur_req = "R5";
        set_line(0, 0);
        pulse_resend();
        settle();

        // R8: rejected message replayed once by a walk
        cur_req = "R8";
        pulse_rej(20);
        settle();
        expect_dlv(3, 20, 5);
        pulse_resend();
        settle();
        pulse_resend();
        settle();

        // R7: end-of-interrupt on a message source does nothing
        cur_req = "R7";
        pulse_eoi(20);
        pulse_resend();
        settle();

        // R8: rejected masked message loses its mark without delivery
        cur_req = "R8";
        pulse_rej(21);
        cfg_write(21, 2, 8'hFF, e);
        pulse_resend();
        settle();
        cfg_write(21, 2, 6, e);
        settle();

        // R11: simultaneous message edges served in ascending order
        cur_req = "R11";
        cfg_write(22, 4, 9, e);
        cfg_write(23, 5, 2, e);
        expect_dlv(4, 22, 9);
        expect_dlv(5, 23, 2);
        @(negedge clk); src_line[7:6] = 2'b11;
        @(negedge clk); src_line[7:6] = 2'b00;
        settle();

        // R12/R5: masked level source, then unmasked by configuration
        cur_req = "R12";
        cfg_write(17, 2, 8'hFF, e);
        set_line(1, 1);
        settle();
        cur_req = "R5";
        expect_dlv(2, 17, 4);
        cfg_write(17, 2, 4, e);
        settle();
        set_line(1, 0);
        settle();

        // R10: walk length and restart
        cur_req = "R10";
        @(negedge clk); resend = 1;
        @(negedge clk); resend = 0;
        cnt = 0;
        while (busy && cnt < 100) begin cnt++; @(negedge clk); end
        chk(cnt == N, "R10 single walk length", 32'(cnt), 32'(N));
        @(negedge clk); resend = 1;
        @(negedge clk); resend = 0;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            resend = (cnt == 3);
            @(negedge clk);
        end
        resend = 0;
        chk(cnt == 2 * N, "R10 restarted walk length", 32'(cnt), 32'(2 * N));
        settle();

        // R1: invalid numbers
        cur_req = "R1";
        cfg_write(15, 1, 0, e);
        chk(e == 1, "R1 error below range", 32'(e), 1);
        cfg_write(24, 9, 0, e);
        chk(e == 1, "R1 error above range", 32'(e), 1);
        cfg_read(24, s, p, v, e);
        chk(e == 1 && v == 0, "R1 invalid read", {30'h0, v, e}, 32'h1);
        cfg_read(16, s, p, v, e);
        chk(e == 0 && s == 1 && p == 3, "R1 table unchanged", {24'h0, s, 4'h0} | 32'(p), 32'h13);
        settle();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule